// File: doc/BRIEF.md
# Escalating Time-Base Watchdog

This block is a watchdog timer driven by a free-running 64-bit time base. The time base advances by one on every cycle in which the tick enable is high. Software programs a 6-bit period value, and that value picks one bit of the time base to watch. Every 0-to-1 transition of the chosen bit is a timeout event. A larger period value selects a lower-order bit, so it gives a shorter timeout.

Timeout events walk an escalation ladder with three steps. The first event only arms the ladder by setting a status flag. The second event sets the interrupt-status flag, and this drives the interrupt output when interrupts are enabled. The third event raises a reset request, which carries the reset action code that software placed in the control register.

Software keeps the watchdog quiet by writing ones to the two flag positions of the status register. The flags are write-one-to-clear. The reset action field locks once it holds a nonzero value, so a runaway program cannot disarm the reset.

Top module: `esc_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the following are all zero: the time base, the control register, both status flags, the interrupt output, the reset request and the reset action output.
- R2: The time base increases by exactly one on each clock edge that sees tick_en high, and holds otherwise. Read address 2 returns bits [31:0] of the time base and read address 3 returns bits [63:32].
- R3: Control word at write/read address 0. Period bits [1:0] sit at bits [31:30] and period bits [5:2] at bits [20:17]. The interrupt enable is bit 26 and the reset action is bits [29:28]. The other bits read as zero. A period value p monitors time-base bit 63-p. A timeout event is the monitored bit being 1 while its value registered at the previous edge was 0.
- R4: A timeout event with both flags clear sets only the armed flag (status bit 31). The interrupt flag and reset request stay low.
- R5: A timeout event while the armed flag is set and the interrupt flag is clear sets the interrupt flag (status bit 30). The irq output equals the interrupt flag ANDed with the interrupt enable.
- R6: A timeout event while both flags are set raises rst_req (also status bit 29) only if the reset action is nonzero. rst_req then stays high until reset, and rst_action shows the action code while rst_req is high and 0 otherwise. With action 00 the event changes nothing.
- R7: Once the reset action is nonzero, further control writes leave it unchanged until reset. The other control fields remain writable.
- R8: A write to status address 1 clears the armed flag where data bit 31 is 1 and the interrupt flag where data bit 30 is 1. Zero bits have no effect. A timeout event in the same cycle acts on the flags as they stand after that clearing.
- R9: With period 0 the monitored bit is bit 63, so no timeout occurs within any practical run. With the interrupt enable at 0, irq stays low while the flags still escalate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read select: 0 control, 1 status, 2 time base low, 3 time base high |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Watchdog interrupt |
| rst_req | output | 1 | Sticky reset request |
| rst_action | output | 2 | Reset action code accompanying rst_req |

## Verification
The hardest states to reach from the ports are the third rung of the ladder, with its action-code split, and the partial clearing of a single flag. Both need several unserviced timeouts to land at a known moment. The stimulus selects period 63, so bit 0 is watched and a single tick pulse gives exactly one event. Gating tick_en then freezes the ladder on a chosen rung while the status writes are applied. A longer period with regular servicing shows the ladder held at its first rung. Stopping the servicing lets it climb into a locked reset request, and a later write then tries to replace the locked action code.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;
  localparam int TB_W      = 64;
  localparam int PER_W     = 6;
  localparam int ACT_W     = 2;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = $clog2(TB_W);

  // control word layout
  localparam int PLO_MSB   = 31;
  localparam int PLO_LSB   = 30;
  localparam int ACT_MSB   = 29;
  localparam int ACT_LSB   = 28;
  localparam int IE_BIT    = 26;
  localparam int PHI_MSB   = 20;
  localparam int PHI_LSB   = 17;

  // status word layout
  localparam int ST_ARM    = 31;
  localparam int ST_INT    = 30;
  localparam int ST_RST    = 29;

  typedef struct packed {
    logic armed;
    logic intr;
    logic rst;
  } esc_state_t;

  function automatic logic [PER_W-1:0] period_of(input logic [DATA_W-1:0] w);
    return {w[PHI_MSB:PHI_LSB], w[PLO_MSB:PLO_LSB]};
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(input logic [PER_W-1:0] per,
                                                  input logic ie,
                                                  input logic [ACT_W-1:0] act);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PLO_MSB:PLO_LSB] = per[1:0];
    w[PHI_MSB:PHI_LSB] = per[5:2];
    w[ACT_MSB:ACT_LSB] = act;
    w[IE_BIT]          = ie;
    return w;
  endfunction

  function automatic logic [IDX_W-1:0] watch_index(input logic [PER_W-1:0] per);
    return IDX_W'(TB_W - 1) - IDX_W'(per);
  endfunction

  // clearing first, then one rung of escalation
  function automatic esc_state_t esc_step(input esc_state_t cur,
                                          input logic [1:0] clr,
                                          input logic ev,
                                          input logic act_nz);
    esc_state_t n;
    n       = cur;
    n.armed = cur.armed & ~clr[1];
    n.intr  = cur.intr  & ~clr[0];
    if (ev) begin
      if (!n.armed)      n.armed = 1'b1;
      else if (!n.intr)  n.intr  = 1'b1;
      else if (act_nz)   n.rst   = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/esc_wdog_timebase.sv
module esc_wdog_timebase #(
  parameter int TB_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  output logic [TB_W-1:0] tb
);
  always_ff @(posedge clk) begin
    if (!rst_n)       tb <= '0;
    else if (tick_en) tb <= tb + TB_W'(1);
  end
endmodule

// File: rtl/esc_wdog_ctrl.sv
module esc_wdog_ctrl
  import esc_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PER_W-1:0]  period,
  output logic              irq_en,
  output logic [ACT_W-1:0]  action,
  output logic [1:0]        clr_mask
);
  logic ctrl_wr, stat_wr, unused_bits;

  assign ctrl_wr = wr_en && !wr_addr;
  assign stat_wr = wr_en &&  wr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      irq_en <= 1'b0;
      action <= '0;
    end else if (ctrl_wr) begin
      period <= period_of(wr_data);
      irq_en <= wr_data[IE_BIT];
      if (action == '0) action <= wr_data[ACT_MSB:ACT_LSB];
    end
  end

  assign clr_mask    = stat_wr ? {wr_data[ST_ARM], wr_data[ST_INT]} : 2'b00;
  assign unused_bits = ^{wr_data[27], wr_data[25:21], wr_data[16:0]};
endmodule

// File: rtl/esc_wdog_ladder.sv
module esc_wdog_ladder
  import esc_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb,
  input  logic [PER_W-1:0] period,
  input  logic [1:0]       clr_mask,
  input  logic             act_nz,
  output logic             tmo_event,
  output esc_state_t       state
);
  logic [IDX_W-1:0] idx;
  logic             watched, watched_q;

  assign idx       = watch_index(period);
  assign watched   = tb[idx];
  assign tmo_event = watched && !watched_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watched_q <= 1'b0;
      state     <= '0;
    end else begin
      watched_q <= watched;
      state     <= esc_step(state, clr_mask, tmo_event, act_nz);
    end
  end
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
  import esc_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              rst_req,
  output logic [1:0]        rst_action
);
  logic [TB_W-1:0]  tb;
  logic [PER_W-1:0] period;
  logic             irq_en;
  logic [ACT_W-1:0] action;
  logic [1:0]       clr_mask;
  logic             tmo_event;
  esc_state_t       state;
  logic [DATA_W-1:0] stat_word;

  esc_wdog_timebase #(.TB_W(TB_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb(tb)
  );

  esc_wdog_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .irq_en(irq_en),
    .action(action), .clr_mask(clr_mask)
  );

  esc_wdog_ladder u_ladder (
    .clk(clk), .rst_n(rst_n), .tb(tb), .period(period),
    .clr_mask(clr_mask), .act_nz(action != '0),
    .tmo_event(tmo_event), .state(state)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[ST_ARM] = state.armed;
    stat_word[ST_INT] = state.intr;
    stat_word[ST_RST] = state.rst;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctrl_word(period, irq_en, action);
      2'd1:    rd_data = stat_word;
      2'd2:    rd_data = tb[31:0];
      default: rd_data = tb[63:32];
    endcase
  end

  assign irq        = state.intr & irq_en;
  assign rst_req    = state.rst;
  assign rst_action = state.rst ? action : '0;
endmodule

// File: rtl/esc_wdog_checker.sv
module esc_wdog_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic [63:0] tb,
  input logic        tmo_event,
  input logic        armed,
  input logic        intr,
  input logic        rst_req,
  input logic [1:0]  action,
  input logic [1:0]  clr_mask,
  input logic        irq,
  input logic        irq_en
);
  assert_tb_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> tb == $past(tb) + 64'd1);

  assert_tb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tb));

  assert_first_rung_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_event && !armed && clr_mask == 2'b00) |=> (armed && !$rose(intr) && !$rose(rst_req)));

  assert_intr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(tmo_event && armed));

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && intr));

  assert_rst_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_rst_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(tmo_event && armed && intr && action != 2'b00));

  assert_action_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (action != 2'b00) |=> $stable(action));

  assert_clear_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[1] && !tmo_event) |=> !armed);
endmodule

bind esc_watchdog esc_wdog_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb(tb),
  .tmo_event(tmo_event), .armed(state.armed), .intr(state.intr),
  .rst_req(rst_req), .action(action), .clr_mask(clr_mask),
  .irq(irq), .irq_en(irq_en)
);

// File: tb/esc_watchdog_test.sv
module esc_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;
  logic [1:0]  rst_action;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit armed_cmp = 0;

  always #5 clk = ~clk;

  esc_watchdog uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req), .rst_action(rst_action)
  );

  // behavioural reference
  bit [63:0] m_tb;
  bit        m_prev, m_ie, m_arm, m_int, m_rst;
  int        m_per;
  bit [1:0]  m_act;

  always @(posedge clk) begin
    bit sel, ev;
    armed_cmp <= 1'b1;
    if (!rst_n) begin
      m_tb = 0; m_prev = 0; m_ie = 0; m_arm = 0; m_int = 0; m_rst = 0;
      m_per = 0; m_act = 0;
    end else begin
      sel = m_tb[63 - m_per];
      ev  = sel && !m_prev;
      if (wr_en && wr_addr) begin
        if (wr_data[31]) m_arm = 0;
        if (wr_data[30]) m_int = 0;
      end
      if (ev) begin
        if (!m_arm)            m_arm = 1;
        else if (!m_int)       m_int = 1;
        else if (m_act != 0)   m_rst = 1;
      end
      m_prev = sel;
      if (tick_en) m_tb = m_tb + 1;
      if (wr_en && !wr_addr) begin
        m_per = {wr_data[20:17], wr_data[31:30]};
        m_ie  = wr_data[26];
        if (m_act == 0) m_act = wr_data[29:28];
      end
    end
  end

  function automatic bit [31:0] m_read(input bit [1:0] a);
    bit [5:0] p;
    p = 6'(m_per);
    case (a)
      2'd0: return (32'(p[1:0]) << 30) | (32'(m_act) << 28) | (32'(m_ie) << 26) | (32'(p[5:2]) << 17);
      2'd1: return {m_arm, m_int, m_rst, 29'd0};
      2'd2: return m_tb[31:0];
      default: return m_tb[63:32];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (armed_cmp) begin
      chk("R5 irq per-cycle", 64'(irq), 64'(m_int & m_ie));
      chk("R6 rst_req per-cycle", 64'(rst_req), 64'(m_rst));
      chk("R6 rst_action per-cycle", 64'(rst_action), 64'(m_rst ? m_act : 2'b00));
      chk("R3 rd_data per-cycle", 64'(rd_data), 64'(m_read(rd_addr)));
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      rd_addr = rd_addr + 2'd1;
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #2;
    d = rd_data;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] cw(input logic [5:0] p, input logic ie, input logic [1:0] a);
    return {p[1:0], a, 1'b0, ie, 5'd0, p[5:2], 17'd0};
  endfunction

  initial begin
    logic [31:0] v;
    int ticks;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 register zero after reset", 64'(v), 64'd0);
    end
    chk("R1 irq low", 64'(irq), 0);
    chk("R1 rst_req low", 64'(rst_req), 0);

    // R3 layout, period 60 (bit 3)
    wr(1'b0, cw(6'd60, 1'b1, 2'b10));
    rd(2'd0, v);
    chk("R3 control layout", 64'(v), 64'h241E0000);

    // R8 servicing keeps ladder low
    tick_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      run(8);
      wr(1'b1, 32'hC000_0000);
    end
    rd(2'd1, v);
    chk("R8 serviced: intr flag clear", 64'(v[30]), 0);
    chk("R8 serviced: no reset", 64'(rst_req), 0);

    // R6 unserviced escalation to reset
    run(70);
    chk("R6 reset requested", 64'(rst_req), 1);
    chk("R6 action code", 64'(rst_action), 64'd2);
    wr(1'b0, cw(6'd60, 1'b1, 2'b01));
    rd(2'd0, v);
    chk("R7 locked action", 64'(v[29:28]), 64'd2);
    wr(1'b1, 32'hE000_0000);
    run(2);
    chk("R6 reset sticky after status write", 64'(rst_req), 1);

    // R4 single event with period 63 (bit 0)
    do_reset();
    wr(1'b0, cw(6'd63, 1'b0, 2'b00));
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    run(3);
    rd(2'd1, v);
    chk("R4 first event arms only", 64'(v), 64'h8000_0000);
    chk("R4 no irq", 64'(irq), 0);

    // R6 action 00 / R9 ie=0
    tick_en = 1'b1;
    run(12);
    tick_en = 1'b0;
    run(3);
    rd(2'd1, v);
    chk("R6 action 00 gives no reset", 64'(v), 64'hC000_0000);
    chk("R9 irq held low with enable off", 64'(irq), 0);
    wr(1'b0, cw(6'd63, 1'b1, 2'b00));
    run(1);
    chk("R5 irq follows enable", 64'(irq), 1);

    // R8 partial clear and zero write
    wr(1'b1, 32'h8000_0000);
    rd(2'd1, v);
    chk("R8 clear armed only", 64'(v), 64'h4000_0000);
    wr(1'b1, 32'h0000_0000);
    rd(2'd1, v);
    chk("R8 zero write no effect", 64'(v), 64'h4000_0000);
    wr(1'b1, 32'h4000_0000);
    rd(2'd1, v);
    chk("R8 clear intr", 64'(v), 0);
    chk("R5 irq drops", 64'(irq), 0);

    // R7 write-once
    wr(1'b0, cw(6'd0, 1'b1, 2'b01));
    wr(1'b0, cw(6'd0, 1'b1, 2'b11));
    rd(2'd0, v);
    chk("R7 action kept", 64'(v), 64'h1400_0000);

    // R9 period 0
    tick_en = 1'b1;
    run(300);
    rd(2'd1, v);
    chk("R9 period 0 no timeout", 64'(v), 0);

    // R2 tick gating and time-base read
    do_reset();
    ticks = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      tick_en = (i % 3) != 0;
      ticks += ((i % 3) != 0) ? 1 : 0;
    end
    @(negedge clk); tick_en = 1'b0;
    rd(2'd2, v);
    chk("R2 time base low word", 64'(v), 64'(ticks));
    rd(2'd3, v);
    chk("R2 time base high word", 64'(v), 0);

    run(4);
    finish_run();
  end
endmodule